// File: doc/BRIEF.md
# Banked Console Address Router

This block sits on the 16-bit bus of a handheld console CPU and routes every access to exactly one destination. The destinations are the boot overlay, the fixed cartridge ROM window, the switchable cartridge ROM window, video RAM, cartridge RAM, the fixed and switchable work RAM banks, sprite attribute memory, the unusable hole above it, the I/O register page, high RAM and the interrupt-enable byte. For each access it raises a one-hot destination select and a physical offset inside that destination. Where a bank applies, the bank number is already folded into the upper offset bits.

The router owns three small pieces of state, all written through ordinary CPU writes in the I/O page: the video RAM bank, the work RAM bank and a sticky latch that retires the boot overlay. Bank selection takes effect only while the console runs in colour mode. The mirror region is folded back onto work RAM before decoding. Reads of the hole return a fixed byte that depends on whether sprite memory is currently blocked. The select and offset outputs are combinational from the address and the registered state, so a downstream memory can use them in the same cycle.

Top module: `cmap_decoder`

## Requirements
- R1: Select bit encoding is 0 boot, 1 ROM fixed, 2 ROM switchable, 3 video RAM, 4 cartridge RAM, 5 work RAM fixed, 6 work RAM switchable, 7 sprite memory, 8 hole, 9 I/O, 10 high RAM, 11 interrupt enable. 0000–3FFF selects bit 1 with offset addr[13:0]. 4000–7FFF selects bit 2 with offset addr[13:0]. 8000–9FFF selects bit 3 with offset {vram_bank, addr[12:0]}. A000–BFFF selects bit 4 with offset addr[12:0].
- R2: C000–CFFF selects bit 5 with offset addr[11:0]. D000–DFFF selects bit 6 with offset {wram_bank, addr[11:0]}.
- R3: An address in E000–FDFF is decoded as the address 0x2000 lower, landing in bit 5 or bit 6 with the matching offset.
- R4: FE00–FE9F selects bit 7 (offset addr[7:0]). FF00–FF7F selects bit 9 (offset addr[6:0]). FF80–FFFE selects bit 10 (offset addr[6:0]). FFFF selects bit 11 (offset 0).
- R5: FEA0–FEFF selects bit 8 with offset addr[7:0]. On a read, hole_rdata is 0xFF while oam_blocked is high and 0x00 otherwise. hole_rdata is 0x00 for every other access. A write there changes no bank or boot state.
- R6: A write to FF4F stores bit 0 as the video bank. vram_bank shows that bit in colour mode and 0 outside colour mode.
- R7: A write to FF70 stores bits 2:0 as the work bank. In colour mode wram_bank shows that value, with a stored 0 shown as 1. Outside colour mode wram_bank is 1.
- R8: While the boot latch is clear, 0000–00FF selects bit 0 with offset addr[7:0]. A write of a non-zero byte to FF50 sets the latch from the next cycle on. A write of zero leaves it unchanged, and once set it stays set until reset.
- R9: During a read or write exactly one select bit is high. With neither strobe high, all select bits are low.
- R10: After reset the boot overlay is active, the stored video bank is 0 and the stored work bank is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| color_mode | input | 1 | High when the console runs in colour mode |
| oam_blocked | input | 1 | High while sprite memory is inaccessible to the CPU |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_wdata | input | 8 | Write data |
| tgt_sel | output | 12 | One-hot destination select |
| phys_addr | output | 16 | Bank-adjusted offset inside the destination |
| hole_rdata | output | 8 | Read data for the unusable hole |
| boot_active | output | 1 | High while the boot overlay is mapped |
| vram_bank | output | 1 | Effective video RAM bank |
| wram_bank | output | 3 | Effective switchable work RAM bank |

## Verification
A stale or corrupted bank register shows up at the ports at the first access to the banked window that follows. The upper bits of phys_addr for 8000–9FFF or D000–DFFF come out wrong in the very cycle of that access, and the bank outputs show the error as soon as the register is loaded. A boot latch that sets on a zero write or clears itself shows as a wrong select on the next access to 0000–00FF. A fault in the mirror fold or the range edges shows as a wrong select bit on the access itself. The bench therefore reads back through the banked windows and the boot range right after every register write and every colour-mode change.

// File: rtl/cmap_pkg.sv
package cmap_pkg;

    localparam int NUM_TGT = 12;
    localparam int TGT_W   = 4;

    typedef enum logic [TGT_W-1:0] {
        T_BOOT  = 4'd0,
        T_ROM0  = 4'd1,
        T_ROMX  = 4'd2,
        T_VRAM  = 4'd3,
        T_XRAM  = 4'd4,
        T_WRAM0 = 4'd5,
        T_WRAMX = 4'd6,
        T_OAM   = 4'd7,
        T_HOLE  = 4'd8,
        T_IO    = 4'd9,
        T_HRAM  = 4'd10,
        T_IE    = 4'd11
    } tgt_e;

endpackage

// File: rtl/cmap_bank_regs.sv
module cmap_bank_regs #(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter int              VBANK_W   = 1,
    parameter int              WBANK_W   = 3,
    parameter logic [ADDR_W-1:0] VBK_ADDR  = 16'hFF4F,
    parameter logic [ADDR_W-1:0] WBK_ADDR  = 16'hFF70,
    parameter logic [ADDR_W-1:0] BOOT_ADDR = 16'hFF50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [VBANK_W-1:0] vbk_o,
    output logic [WBANK_W-1:0] wbk_o,
    output logic               boot_off_o
);

    typedef struct packed {
        logic [VBANK_W-1:0] vbk;
        logic [WBANK_W-1:0] wbk;
        logic               boot_off;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (addr == VBK_ADDR) begin
                regs_d.vbk = wdata[VBANK_W-1:0];
            end
            if (addr == WBK_ADDR) begin
                regs_d.wbk = wdata[WBANK_W-1:0];
            end
            if ((addr == BOOT_ADDR) && (wdata != '0)) begin
                regs_d.boot_off = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign vbk_o      = regs_q.vbk;
    assign wbk_o      = regs_q.wbk;
    assign boot_off_o = regs_q.boot_off;

    // boot latch never falls once set
    assert_boot_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        boot_off_o |=> boot_off_o);

    // a non-zero write to the boot register retires the overlay next cycle
    assert_boot_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == BOOT_ADDR) && (wdata != '0)) |=> boot_off_o);

    // the video bank takes the written bit
    assert_vbk_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == VBK_ADDR)) |=> (vbk_o == $past(wdata[VBANK_W-1:0])));

    // the work bank holds when not addressed
    assert_wbk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == WBK_ADDR)) |=> $stable(wbk_o));

endmodule

// File: rtl/cmap_region.sv
module cmap_region
    import cmap_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BOOT_TOP = 16'h00FF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              boot_on,
    output tgt_e              tgt,
    output logic [ADDR_W-1:0] eff_addr
);

    localparam logic [ADDR_W-1:0] MIR_LO  = 16'hE000;
    localparam logic [ADDR_W-1:0] MIR_HI  = 16'hFDFF;
    localparam logic [ADDR_W-1:0] MIR_OFS = 16'h2000;

    always_comb begin
        if ((addr >= MIR_LO) && (addr <= MIR_HI)) begin
            eff_addr = addr - MIR_OFS;
        end else begin
            eff_addr = addr;
        end

        if (boot_on && (eff_addr <= BOOT_TOP)) begin
            tgt = T_BOOT;
        end else if (eff_addr <= 16'h3FFF) begin
            tgt = T_ROM0;
        end else if (eff_addr <= 16'h7FFF) begin
            tgt = T_ROMX;
        end else if (eff_addr <= 16'h9FFF) begin
            tgt = T_VRAM;
        end else if (eff_addr <= 16'hBFFF) begin
            tgt = T_XRAM;
        end else if (eff_addr <= 16'hCFFF) begin
            tgt = T_WRAM0;
        end else if (eff_addr <= 16'hDFFF) begin
            tgt = T_WRAMX;
        end else if (eff_addr <= 16'hFE9F) begin
            tgt = T_OAM;
        end else if (eff_addr <= 16'hFEFF) begin
            tgt = T_HOLE;
        end else if (eff_addr <= 16'hFF7F) begin
            tgt = T_IO;
        end else if (eff_addr <= 16'hFFFE) begin
            tgt = T_HRAM;
        end else begin
            tgt = T_IE;
        end
    end

endmodule

// File: rtl/cmap_addr_form.sv
module cmap_addr_form
    import cmap_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int VBANK_W = 1,
    parameter int WBANK_W = 3
) (
    input  tgt_e               tgt,
    input  logic [ADDR_W-1:0]  eff_addr,
    input  logic [VBANK_W-1:0] vbank,
    input  logic [WBANK_W-1:0] wbank,
    input  logic               rd_en,
    input  logic               oam_blocked,
    output logic [ADDR_W-1:0]  paddr,
    output logic [DATA_W-1:0]  hole_rdata
);

    localparam int ROM_OFS_W  = 14;
    localparam int VRAM_OFS_W = 13;
    localparam int XRAM_OFS_W = 13;
    localparam int WRAM_OFS_W = 12;
    localparam int PAGE_OFS_W = 8;
    localparam int HI_OFS_W   = 7;

    always_comb begin
        paddr = '0;
        unique case (tgt)
            T_BOOT, T_OAM, T_HOLE: begin
                paddr[PAGE_OFS_W-1:0] = eff_addr[PAGE_OFS_W-1:0];
            end
            T_ROM0, T_ROMX: begin
                paddr[ROM_OFS_W-1:0] = eff_addr[ROM_OFS_W-1:0];
            end
            T_VRAM: begin
                paddr[VRAM_OFS_W-1:0]          = eff_addr[VRAM_OFS_W-1:0];
                paddr[VRAM_OFS_W +: VBANK_W]   = vbank;
            end
            T_XRAM: begin
                paddr[XRAM_OFS_W-1:0] = eff_addr[XRAM_OFS_W-1:0];
            end
            T_WRAM0: begin
                paddr[WRAM_OFS_W-1:0] = eff_addr[WRAM_OFS_W-1:0];
            end
            T_WRAMX: begin
                paddr[WRAM_OFS_W-1:0]        = eff_addr[WRAM_OFS_W-1:0];
                paddr[WRAM_OFS_W +: WBANK_W] = wbank;
            end
            T_IO, T_HRAM: begin
                paddr[HI_OFS_W-1:0] = eff_addr[HI_OFS_W-1:0];
            end
            default: begin
                paddr = '0;
            end
        endcase

        if ((tgt == T_HOLE) && rd_en && oam_blocked) begin
            hole_rdata = '1;
        end else begin
            hole_rdata = '0;
        end
    end

endmodule

// File: rtl/cmap_decoder.sv
module cmap_decoder
    import cmap_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int VBANK_W = 1,
    parameter int WBANK_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               color_mode,
    input  logic               oam_blocked,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic [NUM_TGT-1:0] tgt_sel,
    output logic [ADDR_W-1:0]  phys_addr,
    output logic [DATA_W-1:0]  hole_rdata,
    output logic               boot_active,
    output logic [VBANK_W-1:0] vram_bank,
    output logic [WBANK_W-1:0] wram_bank
);

    localparam logic [WBANK_W-1:0] WBANK_DEF = WBANK_W'(1);

    logic [VBANK_W-1:0] vbk_raw;
    logic [WBANK_W-1:0] wbk_raw;
    logic               boot_off;
    tgt_e               tgt;
    logic [ADDR_W-1:0]  eff_addr;
    logic               access;

    cmap_bank_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .VBANK_W(VBANK_W),
        .WBANK_W(WBANK_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cpu_wr),
        .addr      (cpu_addr),
        .wdata     (cpu_wdata),
        .vbk_o     (vbk_raw),
        .wbk_o     (wbk_raw),
        .boot_off_o(boot_off)
    );

    cmap_region #(
        .ADDR_W(ADDR_W)
    ) u_region (
        .addr    (cpu_addr),
        .boot_on (!boot_off),
        .tgt     (tgt),
        .eff_addr(eff_addr)
    );

    always_comb begin
        if (color_mode) begin
            vram_bank = vbk_raw;
            wram_bank = (wbk_raw == '0) ? WBANK_DEF : wbk_raw;
        end else begin
            vram_bank = '0;
            wram_bank = WBANK_DEF;
        end
    end

    cmap_addr_form #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .VBANK_W(VBANK_W),
        .WBANK_W(WBANK_W)
    ) u_form (
        .tgt        (tgt),
        .eff_addr   (eff_addr),
        .vbank      (vram_bank),
        .wbank      (wram_bank),
        .rd_en      (cpu_rd),
        .oam_blocked(oam_blocked),
        .paddr      (phys_addr),
        .hole_rdata (hole_rdata)
    );

    assign access      = cpu_rd | cpu_wr;
    assign boot_active = !boot_off;

    always_comb begin
        tgt_sel = '0;
        if (access) begin
            tgt_sel[tgt] = 1'b1;
        end
    end

    // exactly one destination per access
    assert_one_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        access |-> ($countones(tgt_sel) == 1));

    // nothing selected while idle
    assert_idle_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !access |-> (tgt_sel == '0));

    // mirror accesses always land in work RAM
    assert_mirror_wram_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (access && (cpu_addr >= 16'hE000) && (cpu_addr <= 16'hFDFF))
        |-> (tgt_sel[T_WRAM0] || tgt_sel[T_WRAMX]));

    // blocked hole reads give all ones
    assert_hole_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_sel[T_HOLE] && cpu_rd && oam_blocked) |-> (hole_rdata == '1));

    // switchable work bank never shows zero
    assert_wbank_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wram_bank != '0);

endmodule

// File: tb/sim_cmap_decoder.sv
`timescale 1ns/1ps
module sim_cmap_decoder;

    localparam int S_BOOT = 0, S_ROM0 = 1, S_ROMX = 2, S_VRAM = 3, S_XRAM = 4,
                   S_WRAM0 = 5, S_WRAMX = 6, S_OAM = 7, S_HOLE = 8, S_IO = 9,
                   S_HRAM = 10, S_IE = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        color_mode = 1'b1;
    logic        oam_blocked = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [11:0] tgt_sel;
    logic [15:0] phys_addr;
    logic [7:0]  hole_rdata;
    logic        boot_active;
    logic        vram_bank;
    logic [2:0]  wram_bank;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic       g_cm  = 1'b1;
    logic       g_blk = 1'b0;
    logic       m_vbk = 1'b0;
    logic [2:0] m_wbk = 3'd0;
    logic       m_boot_off = 1'b0;

    typedef struct {
        logic [15:0] addr;
        logic [11:0] sel;
        logic [15:0] pa;
        logic [7:0]  hd;
        logic        boot;
        logic        vb;
        logic [2:0]  wb;
        int          req;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    cmap_decoder u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .color_mode (color_mode),
        .oam_blocked(oam_blocked),
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .tgt_sel    (tgt_sel),
        .phys_addr  (phys_addr),
        .hole_rdata (hole_rdata),
        .boot_active(boot_active),
        .vram_bank  (vram_bank),
        .wram_bank  (wram_bank)
    );

    function automatic exp_t model(input logic [15:0] a, input logic rd, input logic wr, input int req);
        exp_t e;
        logic [15:0] ea;
        int idx;
        e.addr = a;
        e.req  = req;
        e.boot = !m_boot_off;
        e.vb   = g_cm ? m_vbk : 1'b0;
        e.wb   = !g_cm ? 3'd1 : ((m_wbk == 3'd0) ? 3'd1 : m_wbk);
        ea = ((a >= 16'hE000) && (a <= 16'hFDFF)) ? (a - 16'h2000) : a;
        if (!m_boot_off && ea < 16'h0100) begin idx = S_BOOT;  e.pa = {8'h00, ea[7:0]}; end
        else if (ea < 16'h4000) begin idx = S_ROM0;  e.pa = {2'b00, ea[13:0]}; end
        else if (ea < 16'h8000) begin idx = S_ROMX;  e.pa = {2'b00, ea[13:0]}; end
        else if (ea < 16'hA000) begin idx = S_VRAM;  e.pa = {2'b00, e.vb, ea[12:0]}; end
        else if (ea < 16'hC000) begin idx = S_XRAM;  e.pa = {3'b000, ea[12:0]}; end
        else if (ea < 16'hD000) begin idx = S_WRAM0; e.pa = {4'h0, ea[11:0]}; end
        else if (ea < 16'hE000) begin idx = S_WRAMX; e.pa = {1'b0, e.wb, ea[11:0]}; end
        else if (ea < 16'hFEA0) begin idx = S_OAM;   e.pa = {8'h00, ea[7:0]}; end
        else if (ea < 16'hFF00) begin idx = S_HOLE;  e.pa = {8'h00, ea[7:0]}; end
        else if (ea < 16'hFF80) begin idx = S_IO;    e.pa = {9'h000, ea[6:0]}; end
        else if (ea < 16'hFFFF) begin idx = S_HRAM;  e.pa = {9'h000, ea[6:0]}; end
        else begin idx = S_IE; e.pa = 16'h0000; end
        e.sel = (rd || wr) ? (12'd1 << idx) : 12'd0;
        e.hd  = ((idx == S_HOLE) && rd && g_blk) ? 8'hFF : 8'h00;
        return e;
    endfunction

    // driver: applies one bus cycle and queues its expected result
    task automatic acc(input logic [15:0] a, input logic rd, input logic wr,
                       input logic [7:0] d, input int req);
        @(posedge clk);
        #1;
        color_mode  = g_cm;
        oam_blocked = g_blk;
        cpu_addr    = a;
        cpu_rd      = rd;
        cpu_wr      = wr;
        cpu_wdata   = d;
        sb.push_back(model(a, rd, wr, req));
        if (wr) begin
            if (a == 16'hFF4F) m_vbk = d[0];
            if (a == 16'hFF70) m_wbk = d[2:0];
            if (a == 16'hFF50 && d != 8'h00) m_boot_off = 1'b1;
        end
    endtask

    task automatic rd_at(input logic [15:0] a, input int req);
        acc(a, 1'b1, 1'b0, 8'h00, req);
    endtask

    task automatic wr_at(input logic [15:0] a, input logic [7:0] d, input int req);
        acc(a, 1'b0, 1'b1, d, req);
    endtask

    // monitor: compares queued expectations away from the rising edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (tgt_sel !== e.sel || phys_addr !== e.pa || hole_rdata !== e.hd ||
                boot_active !== e.boot || vram_bank !== e.vb || wram_bank !== e.wb) begin
                bad++;
                $display("FAIL R%0d addr=%h sel=%h/%h pa=%h/%h hd=%h/%h boot=%b/%b vb=%b/%b wb=%0d/%0d (actual/expected)",
                         e.req, e.addr, tgt_sel, e.sel, phys_addr, e.pa, hole_rdata, e.hd,
                         boot_active, e.boot, vram_bank, e.vb, wram_bank, e.wb);
            end
        end
    end

    initial begin
        #(200000.0 * 5.0);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state seen at the ports while reset is held
        total++;
        if (boot_active !== 1'b1 || vram_bank !== 1'b0 || wram_bank !== 3'd1 || tgt_sel !== 12'd0) begin
            bad++;
            $display("FAIL R10 boot=%b vb=%b wb=%0d sel=%h expected 1 0 1 000",
                     boot_active, vram_bank, wram_bank, tgt_sel);
        end
        rst_n = 1'b1;

        acc(16'h1234, 1'b0, 1'b0, 8'h00, 9);   // R9 idle: no select
        rd_at(16'h0000, 8);                     // R8 boot overlay low edge
        rd_at(16'h00FF, 8);                     // R8 boot overlay high edge
        rd_at(16'h0100, 1);                     // R1 just past overlay
        rd_at(16'h3FFF, 1);                     // R1
        rd_at(16'h4000, 1);                     // R1
        rd_at(16'h7FFF, 1);                     // R1
        rd_at(16'h8000, 1);                     // R1
        rd_at(16'h9FFF, 1);                     // R1
        rd_at(16'hA000, 1);                     // R1
        rd_at(16'hBFFF, 1);                     // R1
        rd_at(16'hC123, 2);                     // R2
        rd_at(16'hD456, 2);                     // R2 default bank 1
        rd_at(16'hE123, 3);                     // R3 mirror of fixed bank
        rd_at(16'hF456, 3);                     // R3 mirror of switchable bank
        rd_at(16'hFDFF, 3);                     // R3 top of mirror
        rd_at(16'hFE00, 4);                     // R4
        rd_at(16'hFE9F, 4);                     // R4
        rd_at(16'hFF00, 4);                     // R4
        rd_at(16'hFF7F, 4);                     // R4
        rd_at(16'hFF80, 4);                     // R4
        rd_at(16'hFFFE, 4);                     // R4
        rd_at(16'hFFFF, 4);                     // R4

        g_blk = 1'b1;
        rd_at(16'hFEA0, 5);                     // R5 blocked hole read
        g_blk = 1'b0;
        rd_at(16'hFEFF, 5);                     // R5 unblocked hole read
        g_blk = 1'b1;
        wr_at(16'hFEA0, 8'h57, 5);              // R5 hole write
        rd_at(16'hD010, 5);                     // R5 work bank untouched
        rd_at(16'h0010, 5);                     // R5 boot latch untouched

        wr_at(16'hFF4F, 8'h01, 6);              // R6 select video bank 1
        rd_at(16'h8010, 6);                     // R6
        g_cm = 1'b0;
        rd_at(16'h8010, 6);                     // R6 outside colour mode
        g_cm = 1'b1;
        wr_at(16'hFF4F, 8'hFE, 6);              // R6 bit 0 clear
        rd_at(16'h9F00, 6);                     // R6

        wr_at(16'hFF70, 8'h05, 7);              // R7
        rd_at(16'hD010, 7);                     // R7 bank 5
        wr_at(16'hFF70, 8'h00, 7);              // R7 zero shows as 1
        rd_at(16'hD010, 7);                     // R7
        wr_at(16'hFF70, 8'hFF, 7);              // R7 only low bits kept
        rd_at(16'hF010, 7);                     // R7 via mirror
        g_cm = 1'b0;
        rd_at(16'hD010, 7);                     // R7 outside colour mode
        g_cm = 1'b1;

        wr_at(16'hFF50, 8'h00, 8);              // R8 zero write keeps overlay
        rd_at(16'h0010, 8);                     // R8
        wr_at(16'hFF50, 8'h80, 8);              // R8 retire overlay
        rd_at(16'h0010, 8);                     // R8 now fixed ROM
        rd_at(16'h00FF, 8);                     // R8
        wr_at(16'hFF50, 8'h00, 8);              // R8 sticky
        rd_at(16'h0000, 8);                     // R8
        acc(16'hFF80, 1'b0, 1'b0, 8'h00, 9);    // R9 idle again
        wr_at(16'hFFFF, 8'h1F, 9);              // R9 write selects one target

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule